// File: doc/BRIEF.md
# Nonmaskable Interrupt Request Gate

This block sits between the interrupt pins of a processor subsystem and the core's interrupt entry logic. It watches a synchronous nonmaskable request pin for a rising edge and holds the result as a single pending request. The pin has no request or in-service register bit behind it and takes no part in maskable priority resolution. It merges that request with the winner of the external maskable priority resolver and offers the core one interrupt request. The nonmaskable source always wins. A maskable request is offered only while the core's interrupt-enable flag is set.

When the core acknowledges an offered request, the block records which source was taken. One cycle later it raises a one-cycle pulse that tells the core to clear its interrupt-enable flag. Acknowledging the nonmaskable source drops its pending bit. A fresh edge on the pin sets the bit again, so a new nonmaskable request can preempt a handler that is already running. Because the block keeps no nonmaskable in-service state, software that sets the flag again inside the handler sees maskable requests resolved as if no nonmaskable service were running.

Top module: `nonmask_irq_gate`

## Requirements
- R1: While reset is held and right after it is released, irq_o, flag_clr_o, taken_nmask_o and taken_id_o are 0. A pin that is already high across reset does not create a request.
- R2: If the pin is sampled low at one clock edge and high at the next, a nonmaskable request is pending from that second edge onward: irq_o=1 and sel_nmask_o=1.
- R3: Holding the pin high makes only one request. After that request is acknowledged, none follows until the pin has been sampled low and then high again.
- R4: A pending nonmaskable request is offered whatever the value of flag_i.
- R5: With no nonmaskable request pending, a maskable request is offered only when mreq_valid_i=1 and flag_i=1. It is then offered with sel_nmask_o=0 and sel_id_o=mreq_id_i. In every other case irq_o=0 and sel_id_o=0.
- R6: When a nonmaskable request and an enabled maskable request are present in the same cycle, the nonmaskable one is offered: sel_nmask_o=1 and sel_id_o=0.
- R7: An acknowledge (ack_i=1) in a cycle with irq_o=1 produces flag_clr_o=1 for exactly the next cycle. It also sets taken_nmask_o and taken_id_o to the source offered in that cycle, and they hold until the next acknowledge. An acknowledge while irq_o=0 changes none of these outputs.
- R8: Any further rising edges before the acknowledge merge into the single pending request. One acknowledge of the nonmaskable source clears it.
- R9: A rising edge sampled at the same clock edge that acknowledges the nonmaskable source leaves a new request pending.
- R10: Once the nonmaskable source has been taken, a maskable request with flag_i=1 is offered from the next cycle on. There is no nonmaskable in-service state to block it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmask_pin_i | input | 1 | Synchronous nonmaskable request pin, edge-sensitive |
| mreq_valid_i | input | 1 | Maskable resolver has a winning request |
| mreq_id_i | input | SRC_W (3) | Index of the winning maskable source |
| flag_i | input | 1 | Core interrupt-enable flag |
| ack_i | input | 1 | Core takes the offered interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| sel_nmask_o | output | 1 | The offered request is the nonmaskable source |
| sel_id_o | output | SRC_W (3) | Offered maskable index, 0 otherwise |
| flag_clr_o | output | 1 | One-cycle pulse: clear the interrupt-enable flag |
| taken_nmask_o | output | 1 | The last request taken was nonmaskable |
| taken_id_o | output | SRC_W (3) | Maskable index of the last request taken |

## Verification
Two pairs of events can land in the same cycle. In the first pair, a nonmaskable edge arrives while an enabled maskable request is waiting. The bench provokes this in a directed step and through random traffic, and it requires the nonmaskable source to win with a zero index. In the second pair, a fresh pin edge arrives at the same clock edge as the acknowledge of the nonmaskable source. The bench drives the pin low and then high in the cycle that carries ack_i, and it expects the request to stay pending while flag_clr_o pulses and taken_nmask_o records the nonmaskable take.

// File: rtl/nmg_pkg.sv
package nmg_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_MASK  = 2'd1,
        SRC_NMASK = 2'd2
    } src_kind_e;

endpackage

// File: rtl/nmg_edge_det.sv
module nmg_edge_det #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    typedef struct packed {
        logic lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = pin_i;
        rise_o   = pin_i & ~st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lvl <= RESET_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nmg_pending.sv
module nmg_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    typedef struct packed {
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a new edge wins over a clear in the same cycle
        st_d.pend = set_i | (st_q.pend & ~clr_i);
        pend_o    = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nmg_arbiter.sv
module nmg_arbiter
    import nmg_pkg::*;
#(
    parameter int SRC_W = 3
) (
    input  logic             nm_pend_i,
    input  logic             mreq_valid_i,
    input  logic [SRC_W-1:0] mreq_id_i,
    input  logic             flag_i,
    output src_kind_e        kind_o,
    output logic [SRC_W-1:0] id_o
);

    always_comb begin
        kind_o = SRC_NONE;
        id_o   = '0;
        if (nm_pend_i) begin
            kind_o = SRC_NMASK;
        end else if (mreq_valid_i && flag_i) begin
            kind_o = SRC_MASK;
            id_o   = mreq_id_i;
        end
    end

endmodule

// File: rtl/nonmask_irq_gate.sv
module nonmask_irq_gate
    import nmg_pkg::*;
#(
    parameter int   NUM_SRC       = 8,
    parameter logic PIN_RST_LEVEL = 1'b1,
    localparam int  SRC_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmask_pin_i,
    input  logic             mreq_valid_i,
    input  logic [SRC_W-1:0] mreq_id_i,
    input  logic             flag_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             sel_nmask_o,
    output logic [SRC_W-1:0] sel_id_o,
    output logic             flag_clr_o,
    output logic             taken_nmask_o,
    output logic [SRC_W-1:0] taken_id_o
);

    logic      pin_rise;
    logic      nm_pend;
    logic      nm_clr;
    logic      taken;
    src_kind_e kind;

    typedef struct packed {
        logic             flag_clr;
        logic             t_nmask;
        logic [SRC_W-1:0] t_id;
    } st_t;

    st_t st_d, st_q;

    nmg_edge_det #(
        .RESET_LEVEL (PIN_RST_LEVEL)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmask_pin_i),
        .rise_o (pin_rise)
    );

    nmg_pending u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pin_rise),
        .clr_i  (nm_clr),
        .pend_o (nm_pend)
    );

    nmg_arbiter #(
        .SRC_W (SRC_W)
    ) u_arb (
        .nm_pend_i    (nm_pend),
        .mreq_valid_i (mreq_valid_i),
        .mreq_id_i    (mreq_id_i),
        .flag_i       (flag_i),
        .kind_o       (kind),
        .id_o         (sel_id_o)
    );

    always_comb begin
        irq_o       = (kind != SRC_NONE);
        sel_nmask_o = (kind == SRC_NMASK);
        taken       = ack_i & irq_o;
        nm_clr      = taken & sel_nmask_o;

        st_d          = st_q;
        st_d.flag_clr = taken;
        if (taken) begin
            st_d.t_nmask = sel_nmask_o;
            st_d.t_id    = sel_id_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag_clr <= 1'b0;
            st_q.t_nmask  <= 1'b0;
            st_q.t_id     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_clr_o    = st_q.flag_clr;
    assign taken_nmask_o = st_q.t_nmask;
    assign taken_id_o    = st_q.t_id;

endmodule

// File: rtl/nmg_checker.sv
module nmg_checker #(
    parameter int  NUM_SRC = 8,
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nmask_pin_i,
    input logic             mreq_valid_i,
    input logic [SRC_W-1:0] mreq_id_i,
    input logic             flag_i,
    input logic             ack_i,
    input logic             irq_o,
    input logic             sel_nmask_o,
    input logic [SRC_W-1:0] sel_id_o,
    input logic             flag_clr_o,
    input logic             taken_nmask_o,
    input logic [SRC_W-1:0] taken_id_o
);

    logic pin_prev;
    logic pin_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b1;
        else        pin_prev <= nmask_pin_i;
    end

    assign pin_edge = nmask_pin_i & ~pin_prev;

    p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_edge |=> sel_nmask_o);

    p_nmask_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_nmask_o |-> irq_o);

    p_mask_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_i && !sel_nmask_o) |-> !irq_o);

    p_mask_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid_i && flag_i && !sel_nmask_o) |-> (irq_o && sel_id_o == mreq_id_i));

    p_nmask_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_nmask_o |-> (sel_id_o == '0));

    p_take_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> flag_clr_o);

    p_idle_no_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_i && irq_o) |=> !flag_clr_o);

    p_take_records_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (taken_nmask_o == $past(sel_nmask_o)
                              && taken_id_o == $past(sel_id_o)));

    p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_nmask_o && !ack_i) |=> sel_nmask_o);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_nmask_o && ack_i && !pin_edge) |=> !sel_nmask_o);

    p_reentry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_nmask_o && ack_i && pin_edge) |=> sel_nmask_o);

endmodule

bind nonmask_irq_gate nmg_checker #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/nonmask_irq_gate_tb.sv
module nonmask_irq_gate_tb;

    localparam int NUM_SRC = 8;
    localparam int SRC_W   = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pin, mv, fl, ak;
    logic [SRC_W-1:0] mid;
    logic             irq, snm, fclr, tnm;
    logic [SRC_W-1:0] sid, tid;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // reference state built from the requirements
    logic             m_pend, m_prev, m_clr, m_tnm;
    logic [SRC_W-1:0] m_tid;

    always #10 clk = ~clk;

    nonmask_irq_gate #(.NUM_SRC(NUM_SRC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .nmask_pin_i  (pin),
        .mreq_valid_i (mv),
        .mreq_id_i    (mid),
        .flag_i       (fl),
        .ack_i        (ak),
        .irq_o        (irq),
        .sel_nmask_o  (snm),
        .sel_id_o     (sid),
        .flag_clr_o   (fclr),
        .taken_nmask_o(tnm),
        .taken_id_o   (tid)
    );

    function automatic logic exp_irq();
        return m_pend | (mv & fl);
    endfunction

    function automatic logic [SRC_W-1:0] exp_id();
        return (!m_pend && mv && fl) ? mid : '0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "irq_o", int'(irq), int'(exp_irq()));
        chk(tag, "sel_nmask_o", int'(snm), int'(m_pend));
        chk(tag, "sel_id_o", int'(sid), int'(exp_id()));
        chk(tag, "flag_clr_o", int'(fclr), int'(m_clr));
        chk(tag, "taken_nmask_o", int'(tnm), int'(m_tnm));
        chk(tag, "taken_id_o", int'(tid), int'(m_tid));
    endtask

    // advance the reference across the coming clock edge
    task automatic model_edge();
        logic taken;
        taken = ak & exp_irq();
        if (taken) begin
            m_tnm = m_pend;
            m_tid = exp_id();
        end
        m_clr  = taken;
        m_pend = (pin & ~m_prev) | (m_pend & ~(taken & m_pend));
        m_prev = pin;
    endtask

    task automatic step(input string tag, input logic p, input logic v,
                        input logic [SRC_W-1:0] id, input logic f, input logic a);
        @(negedge clk);
        pin = p; mv = v; mid = id; fl = f; ak = a;
        #2;
        check_all(tag);
        model_edge();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; pin = 1'b1; mv = 1'b0; mid = '0; fl = 1'b0; ak = 1'b0;
        m_pend = 1'b0; m_prev = 1'b1; m_clr = 1'b0; m_tnm = 1'b0; m_tid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state with the pin high
        chk("R1", "irq_o", int'(irq), 0);
        chk("R1", "flag_clr_o", int'(fclr), 0);
        chk("R1", "taken_nmask_o", int'(tnm), 0);
        chk("R1", "taken_id_o", int'(tid), 0);
        model_edge();
        step("R1", 1, 0, 0, 0, 0);
        step("R1", 1, 0, 0, 0, 0);

        // R2/R3: edge then long high level, one request only
        step("R2", 0, 0, 0, 1, 0);
        step("R2", 1, 0, 0, 1, 0);
        step("R3", 1, 0, 0, 1, 0);
        step("R3", 1, 0, 0, 1, 1);
        step("R3", 1, 0, 0, 1, 0);
        step("R3", 1, 0, 0, 1, 0);

        // R4: flag clear does not block the nonmaskable source
        step("R4", 0, 0, 0, 0, 0);
        step("R4", 1, 0, 0, 0, 0);
        step("R4", 1, 0, 0, 0, 1);

        // R5: maskable gated by flag
        step("R5", 0, 1, 3'd5, 0, 0);
        step("R5", 0, 1, 3'd5, 1, 0);
        step("R5", 0, 1, 3'd6, 1, 1);
        step("R7", 0, 0, 3'd6, 1, 0);

        // R6: both present in one cycle
        step("R6", 1, 1, 3'd2, 1, 0);
        step("R6", 1, 1, 3'd2, 1, 1);

        // R7: acknowledge with nothing offered
        step("R7", 0, 0, 3'd4, 0, 1);
        step("R7", 0, 0, 3'd4, 0, 1);

        // R8: two edges merge, one acknowledge clears
        step("R8", 1, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0);
        step("R8", 1, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 0);

        // R9: new edge at the acknowledge edge
        step("R9", 1, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 1);
        step("R9", 1, 0, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 1);

        // R10: flag set again inside the handler, maskable offered at once
        step("R10", 0, 1, 3'd7, 1, 0);
        step("R10", 0, 1, 3'd7, 1, 1);
        step("R10", 0, 0, 3'd7, 1, 0);

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            step("R6", ($urandom % 4) == 0, $urandom % 2, 3'($urandom),
                 ($urandom % 3) != 0, ($urandom % 3) == 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule